// File: doc/BRIEF.md
# Multi-waveform DDS core with frequency keying

The block is a phase-accumulator synthesizer. It runs from one sample clock and produces one unsigned sample word per cycle for an external digital-to-analog converter. A 32-bit accumulator advances by a tuning word on every rising edge. The output frequency is therefore the tuning word times the clock frequency divided by 2^32. The top ten accumulator bits form a table address. That address picks one of three computed waveforms: sine, square or triangle. A control field chooses which waveform reaches the output.

Software configures the block through a simple write port. The port holds two tuning words, a start-phase value and a control word. The control word carries the waveform code and a keying enable. With keying enabled, a serial data bit chooses between the two tuning words on every cycle. A one-cycle phase-reset pulse moves the accumulator to the programmed start phase. A valid flag tells the converter side when the sample pipeline holds real data.

Top module: `dds_multiwave`

## Requirements
- R1: Asynchronous active-low reset clears the accumulator, all four configuration registers, the sample output and the valid flag to zero.
- R2: When no phase reset is requested, each rising edge adds the selected tuning word to the 32-bit accumulator modulo 2^32.
- R3: A high `phase_rst_i` at a rising edge loads the accumulator with the stored start phase and suppresses the addition in that cycle.
- R4: The table address is registered from accumulator bits [31:22] on each edge. The output sample is registered from that address on the next edge, so a sample reflects the accumulator value two edges earlier.
- R5: For address a with h = a mod 512 and m = floor(h*(512-h)*127/65536), the sine sample is 128+m when a < 512 and 127-m otherwise.
- R6: The square sample is 255 for addresses below 512 and 0 from 512 upward.
- R7: The triangle sample is floor(a/2) for a < 512 and 255 - floor((a-512)/2) otherwise.
- R8: Control bits [1:0] pick the waveform: 0 sine, 1 square, 2 triangle, 3 sine. The code in effect when a sample is registered decides that sample, and a code change does not disturb the accumulator.
- R9: With control bit 2 set, a data bit of 1 selects the mark word (address 0) and 0 selects the space word (address 1). With bit 2 clear, the mark word is always used and the data bit has no effect.
- R10: A write (`wr_en_i` high) to address 0 (mark word), 1 (space word), 2 (start phase) or 3 (control) takes effect from the following edge. A phase reset in the same cycle as a start-phase write loads the old value. Writes to addresses 4 to 7 change nothing.
- R11: `sample_valid_o` is low after reset, rises at the second edge after reset release (one cycle after the first registered address) and stays high until the next reset.
- R12: Rewriting a tuning word never resets the accumulator, so the phase runs on continuously across frequency changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 3 | Configuration register select |
| wr_data_i | input | 32 | Configuration write data |
| phase_rst_i | input | 1 | Synchronous load of start phase into accumulator |
| fsk_bit_i | input | 1 | Serial keying data bit |
| sample_o | output | 8 | Unsigned waveform sample |
| sample_valid_o | output | 1 | Sample pipeline holds valid data |

## Verification
A phase-reset pulse can land in the same cycle as a configuration write, or in the same cycle as a keying-bit change. The bench provokes both on purpose. It raises `phase_rst_i` together with a start-phase write, and again together with a tuning-word write while the keying bit toggles. A behavioural model in the bench predicts each sample from the requirements. It expects the old start phase to be loaded, no addition in that cycle, and the new register value to take effect only from the next edge. The output is compared on every clock, so any wrong priority shows up within two cycles as a wrong sample.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [1:0] {
    WAVE_SINE   = 2'd0,
    WAVE_SQUARE = 2'd1,
    WAVE_RAMP   = 2'd2,
    WAVE_SINE_B = 2'd3
  } wave_e;

  localparam logic [2:0] REG_TUNE_MARK  = 3'd0;
  localparam logic [2:0] REG_TUNE_SPACE = 3'd1;
  localparam logic [2:0] REG_PHASE_OFS  = 3'd2;
  localparam logic [2:0] REG_CTRL       = 3'd3;

  typedef struct packed {
    logic  fsk_en;
    wave_e wave;
  } ctrl_t;
endpackage

// File: rtl/dds_cfg_regs.sv
module dds_cfg_regs
  import dds_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [ACC_W-1:0] wr_data_i,
  output logic [ACC_W-1:0] tune_mark_o,
  output logic [ACC_W-1:0] tune_space_o,
  output logic [ACC_W-1:0] phase_ofs_o,
  output ctrl_t            ctrl_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tune_mark_o  <= '0;
      tune_space_o <= '0;
      phase_ofs_o  <= '0;
      ctrl_o       <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        REG_TUNE_MARK:  tune_mark_o  <= wr_data_i;
        REG_TUNE_SPACE: tune_space_o <= wr_data_i;
        REG_PHASE_OFS:  phase_ofs_o  <= wr_data_i;
        REG_CTRL:       ctrl_o       <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] tune_mark_i,
  input  logic [ACC_W-1:0] tune_space_i,
  input  logic             fsk_en_i,
  input  logic             fsk_bit_i,
  input  logic             phase_rst_i,
  input  logic [ACC_W-1:0] phase_ofs_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] step;

  always_comb step = (fsk_en_i && !fsk_bit_i) ? tune_space_i : tune_mark_i;

  // wraps modulo 2^ACC_W; retune never clears phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          acc_o <= '0;
    else if (phase_rst_i) acc_o <= phase_ofs_i;
    else                  acc_o <= acc_o + step;
  end
endmodule

// File: rtl/dds_wave_lut.sv
module dds_wave_lut #(
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SAMP_W-1:0] sine_o,
  output logic [SAMP_W-1:0] square_o,
  output logic [SAMP_W-1:0] ramp_o
);
  localparam int HW    = ADDR_W - 1;
  localparam int HALF  = 1 << HW;
  localparam int SHIFT = 2 * (HW - 1);
  localparam int AMP   = (1 << (SAMP_W - 1)) - 1;
  localparam int PW    = 2 * ADDR_W + SAMP_W;
  localparam logic [SAMP_W-1:0] MID = SAMP_W'(1 << (SAMP_W - 1));

  logic          msb;
  logic [HW-1:0] h;
  logic [SAMP_W-1:0] mag;

  assign msb = addr_i[ADDR_W-1];
  assign h   = addr_i[HW-1:0];

  // parabolic half-wave, peak AMP at quarter period
  assign mag = SAMP_W'((PW'(h) * (PW'(HALF) - PW'(h)) * PW'(AMP)) >> SHIFT);

  assign sine_o   = msb ? (MID - SAMP_W'(1) - mag) : (MID + mag);
  assign square_o = {SAMP_W{~msb}};
  assign ramp_o   = msb ? ~h[HW-1 -: SAMP_W] : h[HW-1 -: SAMP_W];
endmodule

// File: rtl/dds_multiwave.sv
module dds_multiwave
  import dds_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [ACC_W-1:0]  wr_data_i,
  input  logic              phase_rst_i,
  input  logic              fsk_bit_i,
  output logic [SAMP_W-1:0] sample_o,
  output logic              sample_valid_o
);
  logic [ACC_W-1:0]  tune_mark, tune_space, phase_ofs, acc_q;
  ctrl_t             ctrl_q;
  logic              fsk_en;
  logic [1:0]        wave_sel;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_vld_q;
  logic [SAMP_W-1:0] sine_w, square_w, ramp_w, pick;

  assign fsk_en   = ctrl_q.fsk_en;
  assign wave_sel = ctrl_q.wave;

  dds_cfg_regs #(.ACC_W(ACC_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .tune_mark_o (tune_mark),
    .tune_space_o(tune_space),
    .phase_ofs_o (phase_ofs),
    .ctrl_o      (ctrl_q)
  );

  dds_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tune_mark_i (tune_mark),
    .tune_space_i(tune_space),
    .fsk_en_i    (fsk_en),
    .fsk_bit_i   (fsk_bit_i),
    .phase_rst_i (phase_rst_i),
    .phase_ofs_i (phase_ofs),
    .acc_o       (acc_q)
  );

  dds_wave_lut #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_lut (
    .addr_i  (addr_q),
    .sine_o  (sine_w),
    .square_o(square_w),
    .ramp_o  (ramp_w)
  );

  always_comb begin
    case (wave_e'(wave_sel))
      WAVE_SQUARE: pick = square_w;
      WAVE_RAMP:   pick = ramp_w;
      default:     pick = sine_w;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q         <= '0;
      addr_vld_q     <= 1'b0;
      sample_o       <= '0;
      sample_valid_o <= 1'b0;
    end else begin
      addr_q         <= acc_q[ACC_W-1 -: ADDR_W];
      addr_vld_q     <= 1'b1;
      sample_o       <= pick;
      sample_valid_o <= addr_vld_q;
    end
  end
endmodule

// File: rtl/dds_multiwave_chk.sv
module dds_multiwave_chk #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              phase_rst_i,
  input logic              fsk_bit_i,
  input logic [ACC_W-1:0]  acc,
  input logic [ACC_W-1:0]  ofs,
  input logic [ACC_W-1:0]  tune_mark,
  input logic [ACC_W-1:0]  tune_space,
  input logic              fsk_en,
  input logic [1:0]        wave,
  input logic [ADDR_W-1:0] addr,
  input logic [SAMP_W-1:0] sample,
  input logic              valid
);
  p_acc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_rst_i && !(fsk_en && !fsk_bit_i)) |=> acc == $past(acc) + $past(tune_mark));

  p_fsk_space_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_rst_i && fsk_en && !fsk_bit_i) |=> (acc - $past(acc)) == $past(tune_space));

  p_phase_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_rst_i |=> acc == $past(ofs));

  p_addr_track_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> addr == $past(acc[ACC_W-1 -: ADDR_W]));

  p_square_levels_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave == 2'd1) |=> (sample == '0 || sample == '1));

  p_valid_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid |=> valid);
endmodule

bind dds_multiwave dds_multiwave_chk #(
  .ACC_W (ACC_W),
  .ADDR_W(ADDR_W),
  .SAMP_W(SAMP_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .phase_rst_i(phase_rst_i),
  .fsk_bit_i  (fsk_bit_i),
  .acc        (acc_q),
  .ofs        (phase_ofs),
  .tune_mark  (tune_mark),
  .tune_space (tune_space),
  .fsk_en     (fsk_en),
  .wave       (wave_sel),
  .addr       (addr_q),
  .sample     (sample_o),
  .valid      (sample_valid_o)
);

// File: tb/dds_multiwave_tb.sv
`timescale 1ns/1ps
module dds_multiwave_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        phase_rst_i = 1'b0;
  logic        fsk_bit_i = 1'b0;
  logic [7:0]  sample_o;
  logic        sample_valid_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string tag = "R1 reset";

  always #2 clk_i = ~clk_i;

  dds_multiwave u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .phase_rst_i   (phase_rst_i),
    .fsk_bit_i     (fsk_bit_i),
    .sample_o      (sample_o),
    .sample_valid_o(sample_valid_o)
  );

  // behavioural reference
  logic [31:0] m_acc, m_mark, m_space, m_ofs;
  int          m_wave, m_addr, m_samp;
  bit          m_fsk, m_avld, m_val;

  function automatic int ref_wave(input int sel, input int a);
    int h, m;
    if (sel == 1) return (a < 512) ? 255 : 0;
    if (sel == 2) return (a < 512) ? a / 2 : 255 - (a - 512) / 2;
    h = a % 512;
    m = (h * (512 - h) * 127) / 65536;
    return (a < 512) ? 128 + m : 127 - m;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_acc = '0; m_mark = '0; m_space = '0; m_ofs = '0;
      m_wave = 0; m_fsk = 0; m_addr = 0; m_avld = 0; m_samp = 0; m_val = 0;
    end else begin
      m_samp = ref_wave(m_wave, m_addr);
      m_val  = m_avld;
      m_addr = int'(m_acc >> 22);
      m_avld = 1;
      if (phase_rst_i) m_acc = m_ofs;
      else             m_acc = m_acc + ((m_fsk && !fsk_bit_i) ? m_space : m_mark);
      if (wr_en_i) begin
        case (wr_addr_i)
          3'd0: m_mark  = wr_data_i;
          3'd1: m_space = wr_data_i;
          3'd2: m_ofs   = wr_data_i;
          3'd3: begin m_wave = int'(wr_data_i[1:0]); m_fsk = wr_data_i[2]; end
          default: ;
        endcase
      end
    end
  end

  task automatic check_now();
    n_cmp++;
    if (sample_o !== 8'(m_samp) || sample_valid_o !== m_val) begin
      n_bad++;
      $display("FAIL %s: sample=%0d valid=%0b expected sample=%0d valid=%0b",
               tag, sample_o, sample_valid_o, m_samp, m_val);
    end
  endtask

  always @(negedge clk_i) if (!done) check_now();

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic prst();
    phase_rst_i = 1'b1;
    @(negedge clk_i);
    phase_rst_i = 1'b0;
  endtask

  initial begin
    #1;
    tag = "R1 reset outputs";
    check_now();
    step(3);
    tag = "R1 R11 startup";
    rst_ni = 1'b1;
    step(6);

    tag = "R2 R4 R5 sine sweep";
    wr(3'd0, 32'h00C0_0000);
    step(800);

    tag = "R2 wrap";
    wr(3'd0, 32'hFFC0_0000);
    step(60);
    wr(3'd0, 32'h7FF0_1234);
    step(60);

    tag = "R6 R8 square";
    wr(3'd3, 32'd1);
    wr(3'd0, 32'h0123_4567);
    step(300);

    tag = "R7 R8 triangle";
    wr(3'd3, 32'd2);
    step(300);

    tag = "R5 R8 code three";
    wr(3'd3, 32'd3);
    step(100);

    tag = "R3 phase reset";
    wr(3'd2, 32'h8000_0000);
    prst();
    step(20);
    wr(3'd2, 32'h4123_0000);
    prst();
    prst();
    step(20);

    tag = "R3 R10 reset with offset write";
    wr_en_i = 1'b1; wr_addr_i = 3'd2; wr_data_i = 32'hC000_0000; phase_rst_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; phase_rst_i = 1'b0;
    step(10);
    prst();
    step(10);

    tag = "R3 R9 R10 reset with tune write and keying";
    wr(3'd3, 32'd4);
    wr(3'd1, 32'h0300_0000);
    wr_en_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = 32'h0090_0000;
    phase_rst_i = 1'b1; fsk_bit_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; phase_rst_i = 1'b0; fsk_bit_i = 1'b0;
    step(10);

    tag = "R9 keying";
    wr(3'd0, 32'h0100_0000);
    wr(3'd1, 32'h0400_0000);
    wr(3'd3, 32'd6);
    for (int i = 0; i < 200; i++) begin
      fsk_bit_i = ((i * 7) % 5) < 2;
      @(negedge clk_i);
    end

    tag = "R9 keying disabled ignores bit";
    wr(3'd3, 32'd0);
    for (int i = 0; i < 100; i++) begin
      fsk_bit_i = i[0];
      @(negedge clk_i);
    end
    fsk_bit_i = 1'b0;

    tag = "R10 unused addresses";
    for (int i = 4; i < 8; i++) begin
      wr(3'(i), 32'hA5A5_0007 ^ 32'(i * 32'h0111_0000));
      step(3);
    end
    step(50);

    tag = "R12 phase continuity on retune";
    for (int i = 0; i < 6; i++) begin
      wr(3'd0, 32'h0050_0000 + 32'(i) * 32'h0033_1000);
      step(37);
    end

    tag = "R1 mid-run reset";
    #1 rst_ni = 1'b0;
    #1 check_now();
    step(3);
    rst_ni = 1'b1;
    tag = "R1 R11 restart";
    step(10);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule